// File: doc/BRIEF.md
# Self-Correcting Pattern Branch Predictor

This block predicts the direction of a single branch whose outcomes follow a fixed repeating sequence. The sequence is held in a circular history register that is preloaded at reset from a parameter, with 1 meaning taken and 0 meaning not taken. The predicted direction is the most significant bit of that register and appears combinationally on the output.

When the pipeline resolves the branch, it pulses a valid strobe together with the real direction. On that clock edge the register rotates left by one place, so the most significant bit moves into bit 0. If the prediction was wrong, every bit is inverted first and then the register rotates. As a result, the block follows the trained sequence with no misses. It also follows the complement of that sequence after exactly one miss.

Top module: `pattern_flip_predictor`

## Requirements
- R1: While rst_n is low at a rising clock edge, the history register is loaded with PATTERN. After reset, pred_taken equals PATTERN[PAT_LEN-1].
- R2: pred_taken equals the current most significant history bit (1 = taken, 0 = not taken) and changes only on a clock edge.
- R3: On a clock edge where res_valid is low, the history register and pred_taken do not change, whatever res_taken is.
- R4: On a valid edge where res_taken equals pred_taken, the register rotates left by one place: the old bit PAT_LEN-1 goes to bit 0 and every other bit moves up by one position.
- R5: On a valid edge where res_taken differs from pred_taken, all bits are inverted and the result is rotated left by one place. In both R4 and R5, bit 0 afterwards equals the resolved direction.
- R6: If the outcomes fed after reset repeat PATTERN, read from the most significant bit down, no prediction misses.
- R7: If the outcomes fed after reset repeat the bitwise complement of PATTERN, only the first prediction misses.
- R8: Reset is synchronous, and a reset in the middle of a run restores the R1 state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | Strobe: a branch resolved this cycle |
| res_taken | input | 1 | Resolved direction, 1 = taken |
| pred_taken | output | 1 | Predicted direction, 1 = taken |

## Verification
Each result is due one edge after its stimulus. The register update caused by a strobe, or by a reset, is visible on pred_taken at the next falling edge. The prediction that an outcome is compared against is the value present before that edge. The bench therefore samples pred_taken at the falling edge, compares it with its model, and then drives the next inputs. The model advances only after the rising edge. The miss totals for the trained run and the complement run are tallied from those same falling-edge samples.

// File: rtl/pfp_pkg.sv
// Package: shared types for the pattern flip predictor.
// Assumes: a single-bit branch direction encoding.
package pfp_pkg;
    typedef enum logic {
        DIR_NOT_TAKEN = 1'b0,
        DIR_TAKEN     = 1'b1
    } dir_e;
endpackage

// File: rtl/pfp_miss_detect.sv
// Module: pfp_miss_detect
// Flags a wrong prediction on a resolve strobe.
// Assumes: pred_dir is the prediction that was offered for this resolve.
module pfp_miss_detect
    import pfp_pkg::*;
(
    input  logic res_valid,
    input  logic res_dir,
    input  logic pred_dir,
    output logic miss
);
    dir_e actual_d;
    dir_e guess_d;

    // Purpose: compare the guess with the actual direction when a resolve is valid.
    always_comb begin
        actual_d = dir_e'(res_dir);
        guess_d  = dir_e'(pred_dir);
        miss     = res_valid && (actual_d != guess_d);
    end
endmodule

// File: rtl/pfp_history.sv
// Module: pfp_history
// Circular history register. Invert-on-miss is applied before the rotate-left.
// Assumes: PAT_LEN >= 2; miss is asserted only together with advance.
module pfp_history #(
    parameter int unsigned          PAT_LEN = 5,
    parameter logic [PAT_LEN-1:0]   PATTERN = 5'b10110
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               advance,
    input  logic               miss,
    input  logic               res_dir,
    output logic [PAT_LEN-1:0] hist
);
    localparam int unsigned TOP = PAT_LEN - 1;

    logic [PAT_LEN-1:0] nxt;

    // Purpose: each bit takes its right-hand neighbour (bit 0 takes the top bit),
    // inverted on a miss.
    for (genvar i = 0; i < PAT_LEN; i++) begin : g_bit
        localparam int unsigned SRC = (i == 0) ? TOP : i - 1;
        assign nxt[i] = hist[SRC] ^ miss;
    end

    // Purpose: synchronous reset to the pattern, advance on a resolve strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= PATTERN;
        end else if (advance) begin
            hist <= nxt;
        end
    end

    // R1 and R8: a low reset at an edge leaves the pattern in place
    p_reset_load_r1: assert property (@(posedge clk)
        !rst_n |=> hist == PATTERN);

    // R3: no update without a strobe
    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(hist));

    // R4: a hit keeps the same number of taken bits
    p_hit_keeps_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !miss) |=> $countones(hist) == $countones($past(hist)));

    // R5: a miss complements the number of taken bits
    p_miss_flips_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && miss) |=> $countones(hist) == PAT_LEN - $countones($past(hist)));

    // R5: after any resolve, bit 0 holds the resolved direction
    p_lsb_is_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> hist[0] == $past(res_dir));

    // R4: a hit moves the old top bit into bit 0
    p_hit_wraps_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !miss) |=> hist[0] == $past(hist[TOP]));
endmodule

// File: rtl/pattern_flip_predictor.sv
// Module: pattern_flip_predictor
// Top level: predicts one branch from a repeating pattern and
// inverts its history on a miss so that it also follows the complement pattern.
// Assumes: res_valid is pulsed once per resolved branch, in order.
module pattern_flip_predictor #(
    parameter int unsigned          PAT_LEN = 5,
    parameter logic [PAT_LEN-1:0]   PATTERN = 5'b10110
) (
    input  logic clk,
    input  logic rst_n,
    input  logic res_valid,
    input  logic res_taken,
    output logic pred_taken
);
    localparam int unsigned TOP = PAT_LEN - 1;

    logic [PAT_LEN-1:0] hist;
    logic               miss;

    pfp_miss_detect u_miss (
        .res_valid (res_valid),
        .res_dir   (res_taken),
        .pred_dir  (pred_taken),
        .miss      (miss)
    );

    pfp_history #(
        .PAT_LEN (PAT_LEN),
        .PATTERN (PATTERN)
    ) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (res_valid),
        .miss    (miss),
        .res_dir (res_taken),
        .hist    (hist)
    );

    // Purpose: the prediction is the top history bit
    assign pred_taken = hist[TOP];

    // R2: the prediction moves only after a resolve
    p_pred_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(pred_taken));

    // R5: after a miss, the next guess is the inverse of the old second bit
    p_miss_next_guess_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_taken != pred_taken)) |=> pred_taken != $past(hist[TOP-1]));
endmodule

// File: tb/pattern_flip_predictor_bench.sv
module pattern_flip_predictor_bench;
    localparam int unsigned N   = 5;
    localparam logic [N-1:0] PAT = 5'b10110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic res_valid = 1'b0;
    logic res_taken = 1'b0;
    logic pred_taken;

    int applied = 0;
    int fails = 0;
    bit done = 1'b0;

    // Reference model state: a queue of future predictions, front = next guess
    bit model_q[$];

    always #2 clk = ~clk;

    pattern_flip_predictor #(.PAT_LEN(N), .PATTERN(PAT)) u_pattern_flip_predictor (
        .clk        (clk),
        .rst_n      (rst_n),
        .res_valid  (res_valid),
        .res_taken  (res_taken),
        .pred_taken (pred_taken)
    );

    function automatic void model_load();
        model_q.delete();
        for (int k = N - 1; k >= 0; k--) model_q.push_back(PAT[k]);
    endfunction

    function automatic void model_resolve(bit t);
        bit g;
        g = model_q.pop_front();
        model_q.push_back(g);
        if (g != t) begin
            for (int k = 0; k < model_q.size(); k++) model_q[k] = !model_q[k];
        end
    endfunction

    task automatic check(string req, logic act, logic exp);
        applied++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s pred_taken actual=%0b expected=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    // Checks the prediction at the falling edge, drives one cycle, then advances the model.
    // Returns 1 when the model marks this resolve as a miss.
    task automatic step(string req, bit rst, bit v, bit t, output bit was_miss);
        @(negedge clk);
        check(req, pred_taken, model_q[0]);
        was_miss = v && (model_q[0] != t);
        rst_n = rst; res_valid = v; res_taken = t;
        @(posedge clk);
        if (!rst) model_load();
        else if (v) model_resolve(t);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
            $finish;
        end
    end

    initial begin
        bit m;
        int misses;
        logic [15:0] lfsr;

        model_load();
        // R1: reset state
        step("R1", 1'b0, 1'b0, 1'b0, m);
        step("R1", 1'b0, 1'b1, 1'b1, m);
        step("R1", 1'b1, 1'b0, 1'b0, m);

        // R6: trained pattern, three periods, no misses
        misses = 0;
        for (int p = 0; p < 3; p++)
            for (int k = N - 1; k >= 0; k--) begin
                step("R6", 1'b1, 1'b1, PAT[k], m);
                misses += int'(m);
            end
        applied++;
        if (misses != 0) begin
            fails++;
            $display("FAIL R6 misses actual=%0d expected=0", misses);
        end

        // R8: reset mid-run, then R7: complement pattern, exactly one miss
        step("R8", 1'b1, 1'b1, 1'b1, m);
        step("R8", 1'b0, 1'b0, 1'b0, m);
        misses = 0;
        for (int p = 0; p < 3; p++)
            for (int k = N - 1; k >= 0; k--) begin
                step("R7", 1'b1, 1'b1, !PAT[k], m);
                misses += int'(m);
            end
        applied++;
        if (misses != 1) begin
            fails++;
            $display("FAIL R7 misses actual=%0d expected=1", misses);
        end

        // R3: idle cycles with a toggling outcome have no effect
        for (int k = 0; k < 6; k++) step("R3", 1'b1, 1'b0, k[0], m);

        // R2, R4, R5: pseudo-random outcomes with random strobes
        lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] == pred_taken ? "R4" : "R5", 1'b1, lfsr[3] | lfsr[5], lfsr[0], m);
        end

        // R8: a second reset, then R2 check after reset
        step("R8", 1'b0, 1'b1, 1'b0, m);
        step("R2", 1'b1, 1'b0, 1'b0, m);
        step("R2", 1'b1, 1'b0, 1'b0, m);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
        $finish;
    end
endmodule